// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Unit

This block performs every basic arithmetic operation a small datapath needs with a single ripple-carry adder. The first operand `a` goes straight into the adder. The second operand is chosen per bit by a 4-way selector under `op_sel`: `b` itself, its bitwise inverse, all zeros or all ones. A carry-in bit `cin` enters the least significant stage. Together, the two select bits and the carry-in give eight operations: add, add plus one, subtract with and without borrow, transfer, increment, decrement, and transfer again. The result `d` and the carry out of the top stage, `cout`, leave the block together.

Operands enter through a valid/ready handshake and results leave through a second one. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. Back-pressure works as follows. While `out_valid` is high and `out_ready` is low, the result stays frozen. In that state `in_ready` drops, so no further operand can be taken until the consumer drains the held word. The parameter `REGISTERED` chooses between a one-entry output register (the default) and a purely combinational path. In the combinational mode the handshake signals pass straight through. The data width is set by `DATA_W` and defaults to 4.

Top module: `arith_unit`

## Requirements
- R1: With op_sel = 2'b00 the result {cout, d} equals a + b + cin, taken over DATA_W+1 bits.
- R2: With op_sel = 2'b01 the result {cout, d} equals a + (~b) + cin, which is a - b - 1 when cin = 0 and a - b when cin = 1 (modulo 2^DATA_W).
- R3: With op_sel = 2'b10 the result {cout, d} equals a + cin: a transfer when cin = 0, an increment when cin = 1.
- R4: With op_sel = 2'b11 the result {cout, d} equals a + (2^DATA_W - 1) + cin: a decrement when cin = 0, a transfer with cout = 1 when cin = 1.
- R5: For subtraction (op_sel = 2'b01, cin = 1), cout is 1 exactly when a >= b as unsigned numbers, meaning no borrow occurred.
- R6: In registered mode, an operand accepted on a clock edge makes out_valid high after that edge, and its result is the next one delivered. Results come out in the order their operands were accepted.
- R7: While out_valid is high and out_ready is low, out_valid, d and cout stay unchanged on the following edge.
- R8: In registered mode, in_ready equals (not out_valid) or out_ready.
- R9: While rst_n is low, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand word present |
| in_ready | output | 1 | Block can take an operand word this cycle |
| a | input | DATA_W | First operand, fed directly to the adder |
| b | input | DATA_W | Source of the selectable second operand |
| op_sel | input | 2 | Second-operand choice: 00 b, 01 ~b, 10 zeros, 11 ones |
| cin | input | 1 | Carry into the least significant stage |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| d | output | DATA_W | Arithmetic result |
| cout | output | 1 | Carry out of the most significant stage |

## Verification
Two situations are hard to reach from the ports. One is a result that is held under back-pressure while the next operand is already waiting at the input. The other is a borrow edge case such as a = b, or a = 0 with decrement, coming out during such a stall. The stimulus sweeps every operand pair against all eight select and carry combinations. At the same time, out_ready and in_valid follow uneven patterns that are not tied to each other, so stalls fall on every kind of operation. A queue-based model predicts each delivered result and the exact cycle in which out_valid must rise.

// File: rtl/arith_unit_pkg.sv
package arith_unit_pkg;
  typedef enum logic [1:0] {
    OPND_PASS  = 2'b00,
    OPND_INV   = 2'b01,
    OPND_ZERO  = 2'b10,
    OPND_ONES  = 2'b11
  } opnd_sel_e;
endpackage

// File: rtl/arith_unit_opnd_mux.sv
module arith_unit_opnd_mux
  import arith_unit_pkg::*;
#(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        op_sel,
  output logic [DATA_W-1:0] y
);
  opnd_sel_e sel_e;
  assign sel_e = opnd_sel_e'(op_sel);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    always_comb begin
      unique case (sel_e)
        OPND_PASS: y[i] = b[i];
        OPND_INV:  y[i] = ~b[i];
        OPND_ZERO: y[i] = 1'b0;
        OPND_ONES: y[i] = 1'b1;
        default:   y[i] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/arith_unit_full_add.sv
module arith_unit_full_add (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (ci & (x ^ y));
endmodule

// File: rtl/arith_unit_ripple.sv
module arith_unit_ripple #(
  parameter int DATA_W = 4
) (
  input  logic [DATA_W-1:0] x,
  input  logic [DATA_W-1:0] y,
  input  logic              ci,
  output logic [DATA_W-1:0] s,
  output logic              co
);
  logic [DATA_W:0] chain;
  assign chain[0] = ci;

  for (genvar i = 0; i < DATA_W; i++) begin : g_stage
    arith_unit_full_add u_fa (
      .x  (x[i]),
      .y  (y[i]),
      .ci (chain[i]),
      .s  (s[i]),
      .co (chain[i+1])
    );
  end

  assign co = chain[DATA_W];
endmodule

// File: rtl/arith_unit_out_stage.sv
module arith_unit_out_stage #(
  parameter int DATA_W     = 4,
  parameter bit REGISTERED = 1'b1,
  localparam int RES_W     = DATA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [RES_W-1:0] res_in,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [RES_W-1:0] res_out
);
  if (REGISTERED) begin : g_reg
    logic             full_q;
    logic [RES_W-1:0] data_q;

    assign in_ready = !full_q || out_ready;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        full_q <= 1'b0;
        data_q <= '0;
      end else if (in_ready) begin
        full_q <= in_valid;
        if (in_valid) data_q <= res_in;
      end
    end

    assign out_valid = full_q;
    assign res_out   = data_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk ^ rst_n;
    assign in_ready   = out_ready;
    assign out_valid  = in_valid;
    assign res_out    = res_in;
  end
endmodule

// File: rtl/arith_unit.sv
module arith_unit #(
  parameter int DATA_W     = 4,
  parameter bit REGISTERED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic [1:0]        op_sel,
  input  logic              cin,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] d,
  output logic              cout
);
  localparam int RES_W = DATA_W + 1;

  logic [DATA_W-1:0] opnd_y;
  logic [DATA_W-1:0] sum;
  logic              carry;
  logic [RES_W-1:0]  res_out;

  arith_unit_opnd_mux #(.DATA_W(DATA_W)) u_mux (
    .b      (b),
    .op_sel (op_sel),
    .y      (opnd_y)
  );

  arith_unit_ripple #(.DATA_W(DATA_W)) u_add (
    .x  (a),
    .y  (opnd_y),
    .ci (cin),
    .s  (sum),
    .co (carry)
  );

  arith_unit_out_stage #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .res_in    ({carry, sum}),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .res_out   (res_out)
  );

  assign d    = res_out[DATA_W-1:0];
  assign cout = res_out[DATA_W];
endmodule

// File: rtl/arith_unit_chk.sv
module arith_unit_chk #(
  parameter int DATA_W     = 4,
  parameter bit REGISTERED = 1'b1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] a,
  input logic [DATA_W-1:0] b,
  input logic [1:0]        op_sel,
  input logic              cin,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] d,
  input logic              cout
);
  logic [DATA_W:0] exp_add, exp_inv, exp_zero, exp_ones;
  logic            fire, a_ge_b;

  assign exp_add  = {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
  assign exp_inv  = {1'b0, a} + {1'b0, ~b} + {{DATA_W{1'b0}}, cin};
  assign exp_zero = {1'b0, a} + {{DATA_W{1'b0}}, cin};
  assign exp_ones = {1'b0, a} + {1'b0, {DATA_W{1'b1}}} + {{DATA_W{1'b0}}, cin};
  assign fire     = in_valid && in_ready;
  assign a_ge_b   = a >= b;

  assert_reset_idle_R9: assert property (@(posedge clk) !rst_n |-> !out_valid);

  if (REGISTERED) begin : g_reg
    assert_sum_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op_sel == 2'b00) |=> ({cout, d} == $past(exp_add)));
    assert_sum_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op_sel == 2'b01) |=> ({cout, d} == $past(exp_inv)));
    assert_sum_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op_sel == 2'b10) |=> ({cout, d} == $past(exp_zero)));
    assert_sum_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op_sel == 2'b11) |=> ({cout, d} == $past(exp_ones)));
    assert_no_borrow_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && op_sel == 2'b01 && cin) |=> (cout == $past(a_ge_b)));
    assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> out_valid);
    assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(d) && $stable(cout)));
    assert_ready_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready == (!out_valid || out_ready));
  end else begin : g_comb
    assert_comb_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && op_sel == 2'b00) |-> ({cout, d} == exp_add));
    assert_comb_inv_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && op_sel == 2'b01) |-> ({cout, d} == exp_inv));
  end
endmodule

bind arith_unit arith_unit_chk #(.DATA_W(DATA_W), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .a(a), .b(b), .op_sel(op_sel), .cin(cin), .out_valid(out_valid),
  .out_ready(out_ready), .d(d), .cout(cout)
);

// File: tb/sim_arith_unit.sv
`timescale 1ns/1ps
module sim_arith_unit;
  localparam int W     = 4;
  localparam int NVEC  = 8 << (2 * W);
  localparam int LIMIT = 100000;

  typedef struct {
    logic [W:0] val;
    int         tag;
    int         sub_ge;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid, in_ready, out_valid, out_ready, cin, cout;
  logic [W-1:0] a, b, d;
  logic [1:0]   op_sel;

  int   tests = 0, fails = 0, cyc = 0;
  bit   timed_out = 0, done = 0;
  exp_t q[$];
  bit   prev_hold = 0, prev_took = 0;
  logic [W-1:0] prev_d;
  logic         prev_c;

  always #2 clk = ~clk;

  arith_unit #(.DATA_W(W), .REGISTERED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a(a), .b(b), .op_sel(op_sel), .cin(cin), .out_valid(out_valid),
    .out_ready(out_ready), .d(d), .cout(cout)
  );

  function automatic exp_t model(input int av, input int bv, input int s, input int c);
    exp_t e;
    int   mask, opnd, total;
    mask = (1 << W) - 1;
    case (s)
      0:       opnd = bv;
      1:       opnd = (~bv) & mask;
      2:       opnd = 0;
      default: opnd = mask;
    endcase
    total  = av + opnd + c;
    e.val  = total[W:0];
    e.tag  = s + 1;
    e.sub_ge = (s == 1 && c == 1) ? ((av >= bv) ? 1 : 0) : -1;
    return e;
  endfunction

  task automatic cycle(input logic v, input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic [1:0] s, input logic c, input logic ordy, output logic took);
    exp_t e;
    @(negedge clk);
    in_valid = v; a = av; b = bv; op_sel = s; cin = c; out_ready = ordy;
    #1;
    cyc++;
    if (cyc > LIMIT) timed_out = 1;
    if (prev_took) begin
      tests++;
      if (out_valid !== 1'b1) begin
        fails++; $display("FAIL R6 out_valid after accept actual=%b expected=1", out_valid);
      end
    end
    if (prev_hold) begin
      tests++;
      if (out_valid !== 1'b1 || d !== prev_d || cout !== prev_c) begin
        fails++; $display("FAIL R7 held result actual=%b/%h/%b expected=1/%h/%b",
                          out_valid, d, cout, prev_d, prev_c);
      end
    end
    tests++;
    if (in_ready !== (!out_valid || out_ready)) begin
      fails++; $display("FAIL R8 in_ready actual=%b expected=%b", in_ready, !out_valid || out_ready);
    end
    if (out_valid && out_ready) begin
      tests++;
      if (q.size() == 0) begin
        fails++; $display("FAIL R6 unexpected result actual=%h expected=none", {cout, d});
      end else begin
        e = q.pop_front();
        if ({cout, d} !== e.val) begin
          fails++;
          case (e.tag)
            1: $display("FAIL R1 result actual=%h expected=%h", {cout, d}, e.val);
            2: $display("FAIL R2 result actual=%h expected=%h", {cout, d}, e.val);
            3: $display("FAIL R3 result actual=%h expected=%h", {cout, d}, e.val);
            default: $display("FAIL R4 result actual=%h expected=%h", {cout, d}, e.val);
          endcase
        end
        if (e.sub_ge >= 0) begin
          tests++;
          if (int'(cout) != e.sub_ge) begin
            fails++; $display("FAIL R5 no-borrow cout actual=%b expected=%0d", cout, e.sub_ge);
          end
        end
      end
    end
    took = in_valid && in_ready;
    if (took) q.push_back(model(int'(av), int'(bv), int'(s), int'(c)));
    prev_took = took;
    prev_hold = out_valid && !out_ready;
    prev_d = d; prev_c = cout;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #(4 * (LIMIT + 50));
    fails++;
    $display("FAIL R6 watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic took;
    rst_n = 1'b0; in_valid = 0; out_ready = 0; a = '0; b = '0; op_sel = '0; cin = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); #1;
      tests++;
      if (out_valid !== 1'b0) begin
        fails++; $display("FAIL R9 out_valid in reset actual=%b expected=0", out_valid);
      end
    end
    @(negedge clk); rst_n = 1'b1;

    for (int k = 0; k < NVEC && !timed_out; k++) begin
      logic [W-1:0] av, bv;
      logic [1:0]   s;
      logic         c, v, r;
      av = k[W-1:0]; bv = k[2*W-1:W]; s = k[2*W+1:2*W]; c = k[2*W+2];
      do begin
        v = (cyc % 9) != 4;
        r = ((cyc * 7) % 11) < 7;
        cycle(v, av, bv, s, c, r, took);
      end while (!took && !timed_out);
    end

    for (int i = 0; i < 4; i++) cycle(1'b0, '0, '0, 2'b00, 1'b0, 1'b1, took);
    tests++;
    if (q.size() != 0) begin
      fails++; $display("FAIL R6 undelivered results actual=%0d expected=0", q.size());
    end
    if (timed_out) begin
      fails++; $display("FAIL R6 cycle limit actual=%0d expected<=%0d", cyc, LIMIT);
    end
    finish_run();
  end
endmodule